// File: doc/BRIEF.md
# Secure boot entry selector

This block decides where the processor starts executing after a reset and in which protection context it starts. It looks at the lifecycle state code, a pending debug-authentication request, the security-extension enable byte, the root-of-trust select bit, the boot pin, a pending ROM-service command word and the two configured boot addresses (secure and nonsecure). From these it produces a secure vector address, a nonsecure vector address, an initial isolation level (0 or 1) and the core security state.

The decision is a fixed priority tree. The debug request comes first, except in the Locked state. The lifecycle state comes next. Within a state, the security enable, the boot pin, the pending command and the root-of-trust select refine the choice. Each outcome fixes the address, the starting level and the security state together. The ROM-service, debug-authentication and vendor root-of-trust addresses are parameters.

The inputs are sampled on the first rising clock edge after the synchronous reset is released. The results are held from then on until the next reset, whatever the inputs do in the meantime.

Top module: `secure_boot_entry_sel`

## Requirements
- R1: While `rst` is high, both vector outputs read zero, `init_level` reads 0 and `core_secure` reads 1. The decision appears on the outputs directly after the first rising edge at which `rst` is low.
- R2: Once captured, all four outputs keep their values until `rst` is asserted again, even if every input changes.
- R3: A debug request in any lifecycle state other than Locked gives `vtor_s` = debug-authentication address, level 1 and the secure state.
- R4: In the Locked state (code 0x5C) the debug request has no effect on the result.
- R5: Open state (code 0xED), security disabled, no pending command: boot pin 0 gives `vtor_ns` = nonsecure boot address, level 1, nonsecure. Boot pin 1 gives `vtor_s` = ROM-service address, level 0, secure.
- R6: Open state, security enabled, no pending command: boot pin 0 gives `vtor_s` = secure boot address, level 1, secure. Boot pin 1 gives the ROM-service address, level 0, secure.
- R7: Open state with a nonzero service command gives the ROM-service address, level 0, secure, whatever the boot pin and security enable are.
- R8: Provisioning state (code 0x17) without a debug request gives the ROM-service address, level 0, secure.
- R9: Root-of-trust-provisioned (0x2E), Closed (0x72) and Locked states with security disabled give `vtor_ns` = nonsecure boot address, level 1, nonsecure.
- R10: The same three states with security enabled give the vendor root-of-trust address when the select bit is 0 and the secure boot address when it is 1, both at level 1 and secure.
- R11: Regression (0x9A) and nonsecure-regression (0xA6) states without a debug request give the debug-authentication address, level 0, secure.
- R12: Any lifecycle code not listed above behaves exactly as Locked.
- R13: Security enable byte 0xC3 disables the extension. Every other value, including 0xB4 and 0x00, enables it.
- R14: The vector output that belongs to the other security state reads zero: `vtor_ns` when secure, `vtor_s` when nonsecure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lc_code | input | 8 | Lifecycle state code |
| dbg_req | input | 1 | Debug-authentication request |
| tz_byte | input | 8 | Security-extension enable byte |
| rot_sel | input | 1 | Root-of-trust select |
| boot_pin | input | 1 | Boot pin level |
| svc_cmd | input | 16 | Pending ROM-service command (nonzero = pending) |
| sec_boot_addr | input | 32 | Configured secure boot address |
| ns_boot_addr | input | 32 | Configured nonsecure boot address |
| vtor_s | output | 32 | Secure vector address |
| vtor_ns | output | 32 | Nonsecure vector address |
| init_level | output | 2 | Initial isolation level |
| core_secure | output | 1 | Core security state (1 = secure) |

## Verification
All results are due in the same cycle. One register stage lies between the inputs and the outputs, so the result is on the ports after the first rising edge with `rst` low. The bench releases reset at a falling edge, waits for exactly one rising edge and samples at the next falling edge. It then scrambles every input, waits three further edges and samples again to confirm the hold. The reset values are sampled at a falling edge while `rst` is still high. The sweep covers all seven lifecycle codes plus one unlisted code, both debug levels, three enable bytes, both select values, both pin values and zero and nonzero commands.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;
  localparam int LC_W  = 8;
  localparam int TZ_W  = 8;

  localparam logic [LC_W-1:0] LCC_OPEN     = 8'hED;
  localparam logic [LC_W-1:0] LCC_PROV     = 8'h17;
  localparam logic [LC_W-1:0] LCC_ROT_PROV = 8'h2E;
  localparam logic [LC_W-1:0] LCC_CLOSED   = 8'h72;
  localparam logic [LC_W-1:0] LCC_LOCKED   = 8'h5C;
  localparam logic [LC_W-1:0] LCC_REGR     = 8'h9A;
  localparam logic [LC_W-1:0] LCC_NS_REGR  = 8'hA6;
  localparam logic [TZ_W-1:0] TZ_OFF_CODE  = 8'hC3;

  typedef enum logic [2:0] {
    LC_OPEN, LC_PROV, LC_ROT_PROV, LC_CLOSED, LC_LOCKED, LC_REGR, LC_NS_REGR
  } lc_e;

  typedef enum logic [2:0] {
    V_ROM, V_DA, V_ROT, V_SEC_CFG, V_NS_CFG
  } vec_e;

  typedef struct packed {
    vec_e vec;
    logic lvl1;
    logic secure;
  } decision_t;
endpackage

// File: rtl/boot_lc_decode.sv
module boot_lc_decode
  import boot_sel_pkg::*;
(
  input  logic [LC_W-1:0] code,
  output lc_e             lc
);
  always_comb begin
    case (code)
      LCC_OPEN:     lc = LC_OPEN;
      LCC_PROV:     lc = LC_PROV;
      LCC_ROT_PROV: lc = LC_ROT_PROV;
      LCC_CLOSED:   lc = LC_CLOSED;
      LCC_REGR:     lc = LC_REGR;
      LCC_NS_REGR:  lc = LC_NS_REGR;
      default:      lc = LC_LOCKED;  // unlisted codes fall to the strictest state
    endcase
  end
endmodule

// File: rtl/boot_entry_rules.sv
module boot_entry_rules
  import boot_sel_pkg::*;
(
  input  lc_e       lc,
  input  logic      dbg,
  input  logic      sec_en,
  input  logic      rot_sel,
  input  logic      pin,
  input  logic      cmd_pend,
  output decision_t dec
);
  always_comb begin
    dec = '{vec: V_NS_CFG, lvl1: 1'b1, secure: 1'b0};
    if (dbg && lc != LC_LOCKED) begin
      dec = '{vec: V_DA, lvl1: 1'b1, secure: 1'b1};
    end else begin
      case (lc)
        LC_OPEN: begin
          if (cmd_pend || pin)
            dec = '{vec: V_ROM, lvl1: 1'b0, secure: 1'b1};
          else if (sec_en)
            dec = '{vec: V_SEC_CFG, lvl1: 1'b1, secure: 1'b1};
          else
            dec = '{vec: V_NS_CFG, lvl1: 1'b1, secure: 1'b0};
        end
        LC_PROV:
          dec = '{vec: V_ROM, lvl1: 1'b0, secure: 1'b1};
        LC_REGR, LC_NS_REGR:
          dec = '{vec: V_DA, lvl1: 1'b0, secure: 1'b1};
        default: begin
          if (!sec_en)
            dec = '{vec: V_NS_CFG, lvl1: 1'b1, secure: 1'b0};
          else if (rot_sel)
            dec = '{vec: V_SEC_CFG, lvl1: 1'b1, secure: 1'b1};
          else
            dec = '{vec: V_ROT, lvl1: 1'b1, secure: 1'b1};
        end
      endcase
    end
  end
endmodule

// File: rtl/boot_entry_capture.sv
module boot_entry_capture
  import boot_sel_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LVL_W  = 2,
  parameter logic [ADDR_W-1:0] ROM_ADDR = 32'h0BF9_0000,
  parameter logic [ADDR_W-1:0] DA_ADDR  = 32'h0BF9_8000,
  parameter logic [ADDR_W-1:0] ROT_ADDR = 32'h0BFA_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  decision_t         dec,
  input  logic [ADDR_W-1:0] sec_cfg_addr,
  input  logic [ADDR_W-1:0] ns_cfg_addr,
  output logic [ADDR_W-1:0] vtor_s,
  output logic [ADDR_W-1:0] vtor_ns,
  output logic [LVL_W-1:0]  level,
  output logic              secure
);
  logic              done;
  logic [ADDR_W-1:0] addr;

  always_comb begin
    case (dec.vec)
      V_ROM:     addr = ROM_ADDR;
      V_DA:      addr = DA_ADDR;
      V_ROT:     addr = ROT_ADDR;
      V_SEC_CFG: addr = sec_cfg_addr;
      default:   addr = ns_cfg_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      vtor_s  <= '0;
      vtor_ns <= '0;
      level   <= '0;
      secure  <= 1'b1;
    end else if (!done) begin
      done    <= 1'b1;
      vtor_s  <= dec.secure ? addr : '0;
      vtor_ns <= dec.secure ? '0 : addr;
      level   <= {{(LVL_W-1){1'b0}}, dec.lvl1};
      secure  <= dec.secure;
    end
  end

  // R1: reset drives the defined idle values
  p_reset_vals_r1: assert property (@(posedge clk)
    rst |=> (vtor_s == '0 && vtor_ns == '0 && level == '0 && secure));

  // R2: nothing moves after the capture
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> ($stable(vtor_s) && $stable(vtor_ns) && $stable(level) && $stable(secure)));
endmodule

// File: rtl/secure_boot_entry_sel.sv
module secure_boot_entry_sel
  import boot_sel_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LVL_W  = 2,
  parameter int CMD_W  = 16,
  parameter logic [ADDR_W-1:0] ROM_ADDR = 32'h0BF9_0000,
  parameter logic [ADDR_W-1:0] DA_ADDR  = 32'h0BF9_8000,
  parameter logic [ADDR_W-1:0] ROT_ADDR = 32'h0BFA_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LC_W-1:0]   lc_code,
  input  logic              dbg_req,
  input  logic [TZ_W-1:0]   tz_byte,
  input  logic              rot_sel,
  input  logic              boot_pin,
  input  logic [CMD_W-1:0]  svc_cmd,
  input  logic [ADDR_W-1:0] sec_boot_addr,
  input  logic [ADDR_W-1:0] ns_boot_addr,
  output logic [ADDR_W-1:0] vtor_s,
  output logic [ADDR_W-1:0] vtor_ns,
  output logic [LVL_W-1:0]  init_level,
  output logic              core_secure
);
  lc_e       lc;
  decision_t dec;
  logic      sec_en;
  logic      cmd_pend;

  assign sec_en   = (tz_byte != TZ_OFF_CODE);
  assign cmd_pend = |svc_cmd;

  boot_lc_decode u_dec (.code(lc_code), .lc(lc));

  boot_entry_rules u_rules (
    .lc(lc), .dbg(dbg_req), .sec_en(sec_en), .rot_sel(rot_sel),
    .pin(boot_pin), .cmd_pend(cmd_pend), .dec(dec)
  );

  boot_entry_capture #(
    .ADDR_W(ADDR_W), .LVL_W(LVL_W),
    .ROM_ADDR(ROM_ADDR), .DA_ADDR(DA_ADDR), .ROT_ADDR(ROT_ADDR)
  ) u_cap (
    .clk(clk), .rst(rst), .dec(dec),
    .sec_cfg_addr(sec_boot_addr), .ns_cfg_addr(ns_boot_addr),
    .vtor_s(vtor_s), .vtor_ns(vtor_ns), .level(init_level), .secure(core_secure)
  );

  // R3: a debug request outside Locked lands on the authentication entry
  p_dbg_entry_r3: assert property (@(posedge clk) disable iff (rst)
    ($fell(rst) && dbg_req && lc != LC_LOCKED) |=> (vtor_s == DA_ADDR && core_secure));

  // R4: Locked ignores the debug request and always starts at level 1
  p_locked_no_dbg_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(rst) && dbg_req && lc == LC_LOCKED) |=> (init_level == 1));

  // R14: the vector of the other security state is zero
  p_other_vec_zero_r14: assert property (@(posedge clk) disable iff (rst)
    core_secure ? (vtor_ns == '0) : (vtor_s == '0));

  // R5/R9: a nonsecure start is always at level 1
  p_ns_level1_r9: assert property (@(posedge clk) disable iff (rst)
    !core_secure |-> (init_level == 1));
endmodule

// File: tb/tb_secure_boot_entry_sel.sv
module tb_secure_boot_entry_sel;
  localparam logic [31:0] ROM = 32'h0BF9_0000;
  localparam logic [31:0] DA  = 32'h0BF9_8000;
  localparam logic [31:0] ROT = 32'h0BFA_0000;
  localparam logic [31:0] SEC = 32'h0C00_0400;
  localparam logic [31:0] NSA = 32'h0800_0200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  lc_code = 8'h00;
  logic        dbg_req = 1'b0;
  logic [7:0]  tz_byte = 8'hC3;
  logic        rot_sel = 1'b0;
  logic        boot_pin = 1'b0;
  logic [15:0] svc_cmd = 16'h0;
  logic [31:0] sec_boot_addr = SEC;
  logic [31:0] ns_boot_addr = NSA;
  logic [31:0] vtor_s, vtor_ns;
  logic [1:0]  init_level;
  logic        core_secure;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  secure_boot_entry_sel dut (
    .clk(clk), .rst(rst), .lc_code(lc_code), .dbg_req(dbg_req), .tz_byte(tz_byte),
    .rot_sel(rot_sel), .boot_pin(boot_pin), .svc_cmd(svc_cmd),
    .sec_boot_addr(sec_boot_addr), .ns_boot_addr(ns_boot_addr),
    .vtor_s(vtor_s), .vtor_ns(vtor_ns), .init_level(init_level), .core_secure(core_secure)
  );

  function automatic logic [7:0] lc_of(input int i);
    case (i)
      0: return 8'hED; 1: return 8'h17; 2: return 8'h2E; 3: return 8'h72;
      4: return 8'h5C; 5: return 8'h9A; 6: return 8'hA6; default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] tz_of(input int i);
    case (i) 0: return 8'hC3; 1: return 8'hB4; default: return 8'h00; endcase
  endfunction

  // expected {vtor_s, vtor_ns, level, secure}
  function automatic logic [66:0] model(input int li, input int d, input int ti,
                                        input int r, input int p, input int c);
    logic [31:0] a; logic l; logic s; bit en; int st;
    en = (ti != 0);
    st = (li == 7) ? 4 : li;
    if (d == 1 && st != 4) begin a = DA; l = 1; s = 1; end
    else if (st == 0) begin
      if (c != 0 || p == 1) begin a = ROM; l = 0; s = 1; end
      else if (en) begin a = SEC; l = 1; s = 1; end
      else begin a = NSA; l = 1; s = 0; end
    end
    else if (st == 1) begin a = ROM; l = 0; s = 1; end
    else if (st >= 5) begin a = DA; l = 0; s = 1; end
    else if (!en) begin a = NSA; l = 1; s = 0; end
    else if (r == 1) begin a = SEC; l = 1; s = 1; end
    else begin a = ROT; l = 1; s = 1; end
    return {s ? a : 32'h0, s ? 32'h0 : a, 1'b0, l, s};
  endfunction

  function automatic string tag_of(input int li, input int d, input int ti, input int c);
    if (li == 7) return "R12";
    if (d == 1 && li != 4) return "R3";
    if (d == 1) return "R4";
    if (ti == 2) return "R13";
    if (li == 0 && c != 0) return "R7";
    if (li == 0) return (ti == 0) ? "R5" : "R6";
    if (li == 1) return "R8";
    if (li >= 5) return "R11";
    return (ti == 0) ? "R9" : "R10";
  endfunction

  task automatic check(input string tag, input logic [66:0] got, input logic [66:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  initial begin : watchdog
    #1_000_000;
    n_bad++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    for (int li = 0; li < 8; li++)
      for (int d = 0; d < 2; d++)
        for (int ti = 0; ti < 3; ti++)
          for (int r = 0; r < 2; r++)
            for (int p = 0; p < 2; p++)
              for (int c = 0; c < 2; c++) begin
                logic [66:0] exp;
                @(negedge clk);
                rst = 1'b1;
                lc_code = lc_of(li); dbg_req = d[0]; tz_byte = tz_of(ti);
                rot_sel = r[0]; boot_pin = p[0]; svc_cmd = (c != 0) ? 16'h1234 : 16'h0;
                @(posedge clk); @(negedge clk);
                // R1 reset values
                check("R1", {vtor_s, vtor_ns, init_level, core_secure},
                      {32'h0, 32'h0, 2'd0, 1'b1});
                rst = 1'b0;
                @(posedge clk); @(negedge clk);
                exp = model(li, d, ti, r, p, c);
                check(tag_of(li, d, ti, c), {vtor_s, vtor_ns, init_level, core_secure}, exp);
                // R14 other-state vector reads zero
                check("R14", {31'h0, core_secure ? (vtor_ns == 0) : (vtor_s == 0)}, 32'h1);
                // R2 scramble every input and confirm the hold
                lc_code = ~lc_code; dbg_req = ~dbg_req; tz_byte = ~tz_byte;
                rot_sel = ~rot_sel; boot_pin = ~boot_pin; svc_cmd = ~svc_cmd;
                sec_boot_addr = ~SEC; ns_boot_addr = ~NSA;
                repeat (3) @(posedge clk);
                @(negedge clk);
                check("R2", {vtor_s, vtor_ns, init_level, core_secure}, exp);
                sec_boot_addr = SEC; ns_boot_addr = NSA;
              end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule